// File: doc/BRIEF.md
# Accumulator-Register 16-bit Processor Core

This block is a small multicycle processor with a 16-bit data path. Register R0 serves as the accumulator (AC), and R1 to R15 are general registers. R15 also acts as the return-stack pointer. Instructions and data share one word-addressed synchronous memory port, and read data comes back one cycle after the request.

Every instruction is one 16-bit word, split into three fields. Bits 15:12 hold the opcode, bits 11:8 the register or selector `n`, and bits 7:0 the payload. Opcodes 1 to F combine AC with register Rn. Opcode 0 reuses `n` to pick a branch condition or a system operation: jump, call, return, immediate arithmetic, character output, line-input hook, indexed jump or no-op.

The core has five states:
- FETCH issues a read at PC.
- DECODE captures the instruction word and increments PC.
- EXEC carries out the operation. It returns to FETCH or moves to another state.
- LOAD writes the returned memory word into a register or into PC.
- INWAIT holds the line-input request until the external unit reports completion.

The transitions are:
- FETCH→DECODE
- DECODE→EXEC
- EXEC→FETCH, for single-access operations
- EXEC→LOAD, for SET, indirect load, pop, JMP, RET and indexed jump
- EXEC→INWAIT, for the input hook
- LOAD→FETCH
- INWAIT→FETCH, on the done pulse

Top module: `acc16_core`

## Requirements
- R1: On reset, R0 to R14 and PC are zero and R15 is 0x0200. Each instruction is fetched from PC, and PC then advances by one. The first read after reset is at address 0.
- R2: Opcode 1 (SET, encoded 0x1n00) loads Rn from the following word and skips that word. Opcode 2 copies Rn into AC, and opcode 3 copies AC into Rn.
- R3: Opcode 4 loads AC from mem[Rn]. Opcode 5 writes AC to mem[Rn].
- R4: Opcode 6 (pop) loads AC from mem[Rn] and then leaves Rn+1 in Rn. Opcode 7 (push) stores AC at mem[Rn-1] and leaves Rn-1 in Rn.
- R5: Opcodes 8, 9, A, B and F set AC to AC AND Rn, AC OR Rn, AC+Rn, AC-Rn and AC XOR Rn respectively. Results wrap modulo 2^16.
- R6: Opcodes C, D and E replace Rn with ~Rn, Rn-1 and Rn+1 respectively. AC is not changed.
- R7: Opcode 0 with n = 0 to 6 branches always, or when AC (read as signed) is >0, <0, >=0, <=0, !=0 or ==0, in that order of n. The target keeps the upper byte of the already-advanced PC and takes the payload as its lower byte.
- R8: Opcode 0, n=7 sets PC to the word that follows the instruction.
- R9: Opcode 0, n=8 decrements R15, stores the return PC at mem[R15] and jumps to the zero-extended payload. Opcode 0, n=9 loads PC from mem[R15] and then increments R15.
- R10: Opcode 0, n=A adds the zero-extended payload to AC. Opcode 0, n=B subtracts it.
- R11: Opcode 0, n=C raises `out_valid` for exactly one cycle, with `out_data` equal to AC[7:0].
- R12: Opcode 0, n=E sets PC to AC, then loads AC from mem at the new PC. Execution continues from that address.
- R13: Opcode 0, n=F changes no register and no memory, whatever its payload.
- R14: Opcode 0, n=D holds `in_req` high with `in_port` equal to the payload until `in_done` is seen, and then resumes. The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address of the memory access |
| mem_rd | output | 1 | Read request; data is returned on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| out_valid | output | 1 | One-cycle strobe for a character output |
| out_data | output | 8 | Character byte (AC low byte) |
| in_req | output | 1 | Line-input request, held until done |
| in_port | output | 8 | Port number from the payload |
| in_done | input | 1 | Line-input unit completion |

## Verification
The assertions check four things on every cycle:
- the memory port never reads and writes together;
- PC advances by exactly one after each fetch;
- a call always lands on its zero-extended payload;
- the output strobe lasts one cycle, and the input request stays high until it is answered.

Only the bench's programs can show the rest. This covers the data each instruction produces: ALU results across random operands, the signed branch decisions at 0, 0x7FFF, 0x8000 and 0xFFFF, and page-relative targets outside page zero. It also covers the stack contents after call and return, the pre-decrement and post-increment pointer values, and the indexed jump that executes the word it has just loaded.

// File: rtl/acc16_pkg.sv
package acc16_pkg;

    typedef enum logic [2:0] {
        S_FETCH,
        S_DECODE,
        S_EXEC,
        S_LOAD,
        S_INWAIT
    } state_t;

    typedef enum logic [1:0] {
        DST_REG,
        DST_AC,
        DST_PC
    } load_dst_t;

    typedef enum logic [2:0] {
        F_AND,
        F_OR,
        F_ADD,
        F_SUB,
        F_XOR,
        F_NOT,
        F_DEC,
        F_INC
    } alu_fn_t;

    localparam logic [3:0] OPC_SYS   = 4'h0;
    localparam logic [3:0] OPC_SET   = 4'h1;
    localparam logic [3:0] OPC_GET   = 4'h2;
    localparam logic [3:0] OPC_PUT   = 4'h3;
    localparam logic [3:0] OPC_LDI   = 4'h4;
    localparam logic [3:0] OPC_STI   = 4'h5;
    localparam logic [3:0] OPC_POP   = 4'h6;
    localparam logic [3:0] OPC_PUSH  = 4'h7;
    localparam logic [3:0] OPC_AND   = 4'h8;
    localparam logic [3:0] OPC_OR    = 4'h9;
    localparam logic [3:0] OPC_ADD   = 4'hA;
    localparam logic [3:0] OPC_SUB   = 4'hB;
    localparam logic [3:0] OPC_NOT   = 4'hC;
    localparam logic [3:0] OPC_DEC   = 4'hD;
    localparam logic [3:0] OPC_INC   = 4'hE;
    localparam logic [3:0] OPC_XOR   = 4'hF;

    localparam logic [3:0] SYS_JMP   = 4'h7;
    localparam logic [3:0] SYS_CALL  = 4'h8;
    localparam logic [3:0] SYS_RET   = 4'h9;
    localparam logic [3:0] SYS_ADDI  = 4'hA;
    localparam logic [3:0] SYS_SUBI  = 4'hB;
    localparam logic [3:0] SYS_OUT   = 4'hC;
    localparam logic [3:0] SYS_IN    = 4'hD;
    localparam logic [3:0] SYS_IDXJ  = 4'hE;
    localparam logic [3:0] SYS_NOP   = 4'hF;

endpackage

// File: rtl/acc16_alu.sv
module acc16_alu
    import acc16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_t      fn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (fn)
            F_AND:   y = a & b;
            F_OR:    y = a | b;
            F_ADD:   y = a + b;
            F_SUB:   y = a - b;
            F_XOR:   y = a ^ b;
            F_NOT:   y = ~b;
            F_DEC:   y = b - W'(1);
            F_INC:   y = b + W'(1);
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc16_cond.sv
module acc16_cond #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [2:0]   sel,
    output logic         take
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (acc == '0);
    assign is_neg  = acc[W-1];

    always_comb begin
        unique case (sel)
            3'd0:    take = 1'b1;
            3'd1:    take = !is_neg && !is_zero;
            3'd2:    take = is_neg;
            3'd3:    take = !is_neg;
            3'd4:    take = is_neg || is_zero;
            3'd5:    take = !is_zero;
            3'd6:    take = is_zero;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc16_regfile.sv
module acc16_regfile #(
    parameter int          W         = 16,
    parameter int          NREG      = 16,
    parameter logic [15:0] STACK_TOP = 16'h0200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    output logic [W-1:0]            rd_data,
    output logic [W-1:0]            acc,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wsel,
    input  logic [W-1:0]            wdata
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= (i == NREG - 1) ? W'(STACK_TOP) : '0;
            end
        end else if (we) begin
            for (int i = 0; i < NREG; i++) begin
                if (wsel == AW'(i)) regs[i] <= wdata;
            end
        end
    end

    assign rd_data = regs[rd_sel];
    assign acc     = regs[0];
endmodule

// File: rtl/acc16_core.sv
module acc16_core
    import acc16_pkg::*;
#(
    parameter logic [15:0] STACK_TOP = 16'h0200
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        in_req,
    output logic [7:0]  in_port,
    input  logic        in_done
);
    localparam int W    = 16;
    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);
    localparam int PW   = W / 2;
    localparam logic [AW-1:0] SP_IDX = AW'(NREG - 1);

    state_t       state, nxt;
    load_dst_t    dst, dst_nxt;
    logic [W-1:0] pc, pc_nxt;
    logic [W-1:0] ir;

    logic [3:0]    opc;
    logic [AW-1:0] rn;
    logic [PW-1:0] pay;
    logic [W-1:0]  pay_ext;

    logic [AW-1:0] rsel;
    logic [W-1:0]  rval;
    logic [W-1:0]  acc;
    logic          rf_we;
    logic [AW-1:0] rf_wsel;
    logic [W-1:0]  rf_wdata;

    alu_fn_t       fn;
    logic [W-1:0]  alu_b;
    logic [W-1:0]  alu_y;
    logic          take;

    assign opc     = ir[15:12];
    assign rn      = ir[11:8];
    assign pay     = ir[7:0];
    assign pay_ext = {{(W-PW){1'b0}}, pay};
    assign rsel    = (opc == OPC_SYS) ? SP_IDX : rn;

    acc16_regfile #(.W(W), .NREG(NREG), .STACK_TOP(STACK_TOP)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_sel  (rsel),
        .rd_data (rval),
        .acc     (acc),
        .we      (rf_we),
        .wsel    (rf_wsel),
        .wdata   (rf_wdata)
    );

    acc16_alu #(.W(W)) u_alu (
        .a  (acc),
        .b  (alu_b),
        .fn (fn),
        .y  (alu_y)
    );

    acc16_cond #(.W(W)) u_cond (
        .acc  (acc),
        .sel  (rn[2:0]),
        .take (take)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_FETCH;
            pc    <= '0;
            ir    <= '0;
            dst   <= DST_REG;
        end else begin
            state <= nxt;
            pc    <= pc_nxt;
            dst   <= dst_nxt;
            if (state == S_DECODE) ir <= mem_rdata;
        end
    end

    // Output and next-state process
    always_comb begin
        nxt       = state;
        pc_nxt    = pc;
        dst_nxt   = dst;
        mem_addr  = pc;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = acc;
        rf_we     = 1'b0;
        rf_wsel   = '0;
        rf_wdata  = alu_y;
        fn        = F_ADD;
        alu_b     = rval;
        out_valid = 1'b0;
        in_req    = 1'b0;

        unique case (state)
            S_FETCH: begin
                mem_rd = 1'b1;
                nxt    = S_DECODE;
            end
            S_DECODE: begin
                pc_nxt = pc + W'(1);
                nxt    = S_EXEC;
            end
            S_EXEC: begin
                nxt = S_FETCH;
                unique case (opc)
                    OPC_SET: begin
                        mem_rd  = 1'b1;
                        pc_nxt  = pc + W'(1);
                        dst_nxt = DST_REG;
                        nxt     = S_LOAD;
                    end
                    OPC_GET: begin
                        rf_we    = 1'b1;
                        rf_wdata = rval;
                    end
                    OPC_PUT: begin
                        rf_we    = 1'b1;
                        rf_wsel  = rn;
                        rf_wdata = acc;
                    end
                    OPC_LDI: begin
                        mem_rd   = 1'b1;
                        mem_addr = rval;
                        dst_nxt  = DST_AC;
                        nxt      = S_LOAD;
                    end
                    OPC_STI: begin
                        mem_wr   = 1'b1;
                        mem_addr = rval;
                    end
                    OPC_POP: begin
                        mem_rd   = 1'b1;
                        mem_addr = rval;
                        fn       = F_INC;
                        rf_we    = 1'b1;
                        rf_wsel  = rn;
                        dst_nxt  = DST_AC;
                        nxt      = S_LOAD;
                    end
                    OPC_PUSH: begin
                        fn       = F_DEC;
                        mem_wr   = 1'b1;
                        mem_addr = alu_y;
                        rf_we    = 1'b1;
                        rf_wsel  = rn;
                    end
                    OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_XOR: begin
                        unique case (opc)
                            OPC_AND: fn = F_AND;
                            OPC_OR:  fn = F_OR;
                            OPC_ADD: fn = F_ADD;
                            OPC_SUB: fn = F_SUB;
                            default: fn = F_XOR;
                        endcase
                        rf_we = 1'b1;
                    end
                    OPC_NOT, OPC_DEC, OPC_INC: begin
                        unique case (opc)
                            OPC_NOT: fn = F_NOT;
                            OPC_DEC: fn = F_DEC;
                            default: fn = F_INC;
                        endcase
                        rf_we   = 1'b1;
                        rf_wsel = rn;
                    end
                    default: begin
                        unique case (rn)
                            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6: begin
                                if (take) pc_nxt = {pc[W-1:PW], pay};
                            end
                            SYS_JMP: begin
                                mem_rd  = 1'b1;
                                dst_nxt = DST_PC;
                                nxt     = S_LOAD;
                            end
                            SYS_CALL: begin
                                fn        = F_DEC;
                                mem_wr    = 1'b1;
                                mem_addr  = alu_y;
                                mem_wdata = pc;
                                rf_we     = 1'b1;
                                rf_wsel   = SP_IDX;
                                pc_nxt    = pay_ext;
                            end
                            SYS_RET: begin
                                mem_rd   = 1'b1;
                                mem_addr = rval;
                                fn       = F_INC;
                                rf_we    = 1'b1;
                                rf_wsel  = SP_IDX;
                                dst_nxt  = DST_PC;
                                nxt      = S_LOAD;
                            end
                            SYS_ADDI, SYS_SUBI: begin
                                fn    = (rn == SYS_ADDI) ? F_ADD : F_SUB;
                                alu_b = pay_ext;
                                rf_we = 1'b1;
                            end
                            SYS_OUT: begin
                                out_valid = 1'b1;
                            end
                            SYS_IN: begin
                                nxt = S_INWAIT;
                            end
                            SYS_IDXJ: begin
                                pc_nxt   = acc;
                                mem_rd   = 1'b1;
                                mem_addr = acc;
                                dst_nxt  = DST_AC;
                                nxt      = S_LOAD;
                            end
                            default: begin
                            end
                        endcase
                    end
                endcase
            end
            S_LOAD: begin
                nxt = S_FETCH;
                unique case (dst)
                    DST_PC: pc_nxt = mem_rdata;
                    DST_AC: begin
                        rf_we    = 1'b1;
                        rf_wdata = mem_rdata;
                    end
                    default: begin
                        rf_we    = 1'b1;
                        rf_wsel  = rn;
                        rf_wdata = mem_rdata;
                    end
                endcase
            end
            S_INWAIT: begin
                in_req = 1'b1;
                if (in_done) nxt = S_FETCH;
            end
            default: nxt = S_FETCH;
        endcase
    end

    assign out_data = acc[7:0];
    assign in_port  = pay;

    // R14: the memory port never reads and writes in one cycle
    a_r14_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R1: PC advances by one after every fetch
    a_r1_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE) |=> (pc == $past(pc) + W'(1)));

    // R9: a call lands on its zero-extended payload
    a_r9_call_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && opc == OPC_SYS && rn == SYS_CALL)
        |=> (state == S_FETCH && pc == {{(W-PW){1'b0}}, $past(ir[7:0])}));

    // R11: the character strobe is a single-cycle pulse
    a_r11_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R14: the input request stays up until it is answered
    a_r14_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && !in_done) |=> in_req);

endmodule

// File: tb/acc16_core_test.sv
module acc16_core_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        in_req;
    logic [7:0]  in_port;
    logic        in_done = 1'b0;

    logic [15:0] mem [0:1023];
    int          wp;
    int          n_chk = 0;
    int          n_bad = 0;
    int          out_cnt = 0;
    logic [7:0]  out_last = '0;
    int          inreq_cycles = 0;
    logic [7:0]  port_seen = '0;
    bit          done = 1'b0;
    logic [15:0] vals [8];

    acc16_core uut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data),
        .in_req(in_req), .in_port(in_port), .in_done(in_done)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                out_cnt++;
                out_last = out_data;
            end
            if (rst_n && in_req) begin
                inreq_cycles++;
                port_seen = in_port;
                if (inreq_cycles == 4) begin
                    in_done = 1'b1;
                    @(negedge clk);
                    in_done = 1'b0;
                end
            end
        end
    end

    function automatic logic [15:0] alu_ref(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'h8:    return a & b;
            4'h9:    return a | b;
            4'hA:    return a + b;
            4'hB:    return a - b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic bit cond_ref(input int n, input logic [15:0] v);
        int s;
        s = $signed(v);
        case (n)
            0: return 1;
            1: return s > 0;
            2: return s < 0;
            3: return s >= 0;
            4: return s <= 0;
            5: return s != 0;
            default: return s == 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic new_prog();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        wp = 0;
        out_cnt = 0;
        inreq_cycles = 0;
    endtask

    task automatic emit(input logic [15:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic store_ac(input logic [15:0] a);
        emit(16'h1200);
        emit(a);
        emit(16'h5200);
    endtask

    task automatic halt();
        emit({8'h00, 8'(wp)});
    endtask

    task automatic run(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        logic [15:0] a, b;
        void'($urandom(32'd1357));
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;
        vals[6] = 16'(($urandom() & 16'h7FFF) | 16'h0100);
        vals[7] = 16'($urandom() | 16'h8000);

        // R2: moves through R3
        new_prog();
        emit(16'h1000); emit(16'hBEEF); emit(16'h3300);
        emit(16'h1000); emit(16'h0000); emit(16'h2300);
        store_ac(16'h0300); halt();
        run(100);
        chk("R2 put/get", mem[16'h300], 16'hBEEF);

        // R1: reset state, first fetch address, R15 top
        new_prog();
        emit(16'h2F00); store_ac(16'h0300);
        emit(16'h2300); emit(16'hE200); emit(16'h5200); halt();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first read", {15'd0, mem_rd}, 16'd1);
        chk("R1 first addr", mem_addr, 16'h0000);
        repeat (100) @(negedge clk);
        chk("R1 R15 reset", mem[16'h300], 16'h0200);
        chk("R1 R3 reset", mem[16'h301], 16'h0000);

        // R5: random ALU ops
        for (int k = 0; k < 40; k++) begin
            logic [3:0] op;
            case (k % 5)
                0: op = 4'h8; 1: op = 4'h9; 2: op = 4'hA; 3: op = 4'hB;
                default: op = 4'hF;
            endcase
            a = (k < 5) ? 16'hFFFF : 16'($urandom());
            b = (k < 5) ? 16'h0001 : 16'($urandom());
            new_prog();
            emit(16'h1000); emit(a); emit(16'h1100); emit(b);
            emit({op, 4'h1, 8'h00});
            store_ac(16'h0300); halt();
            run(100);
            chk("R5 alu", mem[16'h300], alu_ref(op, a, b));
        end

        // R6: unary on Rn, AC untouched
        for (int k = 0; k < 12; k++) begin
            logic [3:0] op;
            logic [15:0] e;
            op = 4'hC + 4'(k % 3);
            a = (k < 3) ? 16'h0000 : (k < 6) ? 16'hFFFF : 16'($urandom());
            e = (op == 4'hC) ? ~a : (op == 4'hD) ? a - 16'd1 : a + 16'd1;
            new_prog();
            emit(16'h1000); emit(16'h5A5A);
            emit(16'h1100); emit(a); emit({op, 4'h1, 8'h00});
            store_ac(16'h0300); emit(16'h2100); emit(16'hE200); emit(16'h5200); halt();
            run(100);
            chk("R6 ac kept", mem[16'h300], 16'h5A5A);
            chk("R6 unary", mem[16'h301], e);
        end

        // R3: indirect load and store
        new_prog();
        mem[16'h310] = 16'hC0DE;
        emit(16'h1400); emit(16'h0310); emit(16'h4400);
        store_ac(16'h0300); halt();
        run(100);
        chk("R3 load ind", mem[16'h300], 16'hC0DE);

        // R4: pop post-increments
        new_prog();
        mem[16'h320] = 16'h7777;
        emit(16'h1500); emit(16'h0320); emit(16'h6500);
        store_ac(16'h0300); emit(16'h2500); emit(16'hE200); emit(16'h5200); halt();
        run(100);
        chk("R4 pop data", mem[16'h300], 16'h7777);
        chk("R4 pop ptr", mem[16'h301], 16'h0321);

        // R4: push pre-decrements
        new_prog();
        emit(16'h1000); emit(16'h4242); emit(16'h1600); emit(16'h0330);
        emit(16'h7600); emit(16'h2600); store_ac(16'h0300); halt();
        run(100);
        chk("R4 push data", mem[16'h32F], 16'h4242);
        chk("R4 push ptr", mem[16'h300], 16'h032F);

        // R7: branch conditions on signed AC
        for (int n = 0; n <= 6; n++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] v;
                v = vals[j];
                new_prog();
                emit(16'h1000); emit(v); emit(16'h1200); emit(16'h0300);
                emit({4'h0, 4'(n), 8'h07}); emit(16'h0A01); emit(16'h0F00);
                emit(16'h5200); halt();
                run(100);
                chk("R7 branch", mem[16'h300], cond_ref(n, v) ? v : v + 16'd1);
            end
        end

        // R7 and R8: long jump then page-relative branch in page 1
        new_prog();
        emit(16'h0700); emit(16'h0150);
        mem[16'h150] = 16'h0060;
        mem[16'h160] = 16'h1000; mem[16'h161] = 16'h1234;
        mem[16'h162] = 16'h1200; mem[16'h163] = 16'h0300;
        mem[16'h164] = 16'h5200; mem[16'h165] = 16'h0065;
        run(100);
        chk("R8 jmp + R7 page", mem[16'h300], 16'h1234);

        // R9: call and return
        new_prog();
        emit(16'h0820); emit(16'h0A05); store_ac(16'h0300);
        emit(16'h2F00); emit(16'hE200); emit(16'h5200); halt();
        mem[16'h20] = 16'h1000; mem[16'h21] = 16'h0040; mem[16'h22] = 16'h0900;
        run(120);
        chk("R9 ret path", mem[16'h300], 16'h0045);
        chk("R9 sp restore", mem[16'h301], 16'h0200);
        chk("R9 ret addr", mem[16'h1FF], 16'h0001);

        // R10: immediate add and subtract
        for (int k = 0; k < 12; k++) begin
            logic [7:0] p;
            logic sub;
            sub = k[0];
            a = (k < 2) ? 16'hFFFF : (k < 4) ? 16'h0000 : 16'($urandom());
            p = (k < 4) ? 8'hFF : 8'($urandom());
            new_prog();
            emit(16'h1000); emit(a); emit({4'h0, sub ? 4'hB : 4'hA, p});
            store_ac(16'h0300); halt();
            run(100);
            chk("R10 imm", mem[16'h300], sub ? a - {8'h00, p} : a + {8'h00, p});
        end

        // R11: output strobe
        new_prog();
        emit(16'h1000); emit(16'h1241); emit(16'h0C00); halt();
        run(100);
        chk("R11 out count", 16'(out_cnt), 16'd1);
        chk("R11 out byte", {8'h00, out_last}, 16'h0041);

        // R12: indexed jump loads and then executes target word
        new_prog();
        emit(16'h1000); emit(16'h0040); emit(16'h0E00);
        mem[16'h40] = 16'h0A03; mem[16'h41] = 16'h1200; mem[16'h42] = 16'h0300;
        mem[16'h43] = 16'h5200; mem[16'h44] = 16'h0044;
        run(100);
        chk("R12 idx jump", mem[16'h300], 16'h0A06);

        // R13: no-op with nonzero payload
        new_prog();
        emit(16'h1000); emit(16'h3C3C); emit(16'h0F37);
        store_ac(16'h0300); halt();
        run(100);
        chk("R13 nop ac", mem[16'h300], 16'h3C3C);
        chk("R13 nop mem", mem[16'h37], 16'h0000);

        // R14: input hook stall and resume
        new_prog();
        emit(16'h0D05); emit(16'h1000); emit(16'h0055); emit(16'h0C00); halt();
        run(100);
        chk("R14 in port", {8'h00, port_seen}, 16'h0005);
        chk("R14 in hold", 16'(inreq_cycles), 16'd4);
        chk("R14 resume", {8'h00, out_last}, 16'h0055);

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule